// File: doc/BRIEF.md
# Single-Cycle Accumulator Processor Core

This block is a small processor that completes one instruction per clock. A 12-bit program counter addresses an external program ROM. The ROM returns a 16-bit instruction in the same cycle. The core decodes that instruction and picks its B operand, either the zero-extended constant field or the word read from the data RAM. It then passes B through, adds it to the accumulator, or subtracts it from the accumulator. At the clock edge it updates the accumulator, the data-address register, the write-request register and the program counter.

The data RAM has a combinational read port and a clocked write port. The RAM address always comes from the data-address register. That register captures the low 12 bits of B on every instruction, so a memory operand uses the address left behind by the previous instruction. A load from memory therefore follows an ADDR instruction that names the location. A STORE only clears the write-request register, and the RAM write happens one cycle later. It writes the accumulator to the address that the STORE loaded.

An illegal opcode stops the core. The core raises a sticky error output and freezes its architectural state until the next reset.

Top module: `acc_core`

## Requirements
- R1: A synchronous active-high reset sets `rom_addr`, `ram_addr` and `ram_wdata` to 0 and drives `ram_we` and `illegal` low. No RAM write occurs in the first cycle after reset.
- R2: An instruction carries its opcode in bits [15:13] and its operand source in bit 12 (0 selects the constant, 1 selects `ram_rdata`). Bits [11:0] hold a constant that is zero-extended to 16 bits. Opcode codes: ADDR=0, LOAD=1, STORE=2, ADD=3, SUB=4, JUMP=5, JUMPZ=6, and 7 is illegal.
- R3: LOAD writes B into the accumulator, ADD writes accumulator+B and SUB writes accumulator-B, both modulo 2^16. The accumulator is visible on `ram_wdata` from the next cycle on.
- R4: ADDR, STORE, JUMP and JUMPZ leave the accumulator unchanged.
- R5: Every legal instruction loads the low 12 bits of B into the data-address register. That register drives `ram_addr` from the next cycle on.
- R6: `ram_we` is high in exactly the cycle after a STORE. In that cycle `ram_addr` is the STORE's operand and `ram_wdata` is the accumulator, and the write commits at the closing clock edge.
- R7: JUMP always loads the low 12 bits of B into the program counter. JUMPZ does the same only when B is zero, whatever the accumulator holds.
- R8: When no branch is taken, the program counter advances by one and wraps from 0xFFF to 0x000.
- R9: Decoding opcode 7 sets `illegal` from the next cycle until reset. From then on the program counter, accumulator and data-address register hold their values and no RAM write starts.
- R10: The five-instruction loop ADDR 2, LOAD (memory), ADD 1, STORE 2, JUMP 0 increments RAM word 2 by one on each five-cycle pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rom_addr | output | 12 | Program counter, address to the program ROM |
| rom_data | input | 16 | Instruction word read combinationally from the ROM |
| ram_addr | output | 12 | Data RAM address (data-address register) |
| ram_rdata | input | 16 | Word read combinationally from the RAM |
| ram_wdata | output | 16 | Write data to the RAM (the accumulator) |
| ram_we | output | 1 | RAM write enable, committed at the clock edge |
| illegal | output | 1 | Sticky illegal-opcode flag |

## Verification
Every output comes straight from a register. The result of the instruction on `rom_data` in a cycle therefore appears on the ports one clock edge later. The single exception is a STORE, whose RAM write shows in the cycle after its own and reaches the RAM contents at the edge after that. The bench keeps a reference state that it advances once per cycle from the same ROM and RAM contents. It compares the ports with that state half a period after each rising edge, before the model takes its next step. The directed checks use the same timing: they inspect `ram_we` one cycle after a STORE and read the RAM word one edge later.

// File: rtl/acc_pkg.sv
package acc_pkg;

  localparam int OPC_W = 3;

  typedef enum logic [OPC_W-1:0] {
    OP_ADDR  = 3'd0,
    OP_LOAD  = 3'd1,
    OP_STORE = 3'd2,
    OP_ADD   = 3'd3,
    OP_SUB   = 3'd4,
    OP_JUMP  = 3'd5,
    OP_JUMPZ = 3'd6,
    OP_BAD   = 3'd7
  } opcode_e;

  typedef enum logic [1:0] {
    FN_PASS = 2'd0,
    FN_ADD  = 2'd1,
    FN_SUB  = 2'd2
  } alu_fn_e;

  typedef struct packed {
    alu_fn_e fn;
    logic    acc_we;
    logic    store;
    logic    jump;
    logic    force_z;
    logic    bad;
  } ctrl_t;

endpackage

// File: rtl/acc_decode.sv
module acc_decode
  import acc_pkg::*;
(
  input  logic [OPC_W-1:0] opc,
  output ctrl_t            ctrl
);

  always_comb begin
    ctrl = '{fn: FN_PASS, acc_we: 1'b0, store: 1'b0, jump: 1'b0,
             force_z: 1'b0, bad: 1'b0};
    case (opcode_e'(opc))
      OP_ADDR:  ;
      OP_LOAD:  ctrl.acc_we = 1'b1;
      OP_STORE: ctrl.store  = 1'b1;
      OP_ADD: begin
        ctrl.fn     = FN_ADD;
        ctrl.acc_we = 1'b1;
      end
      OP_SUB: begin
        ctrl.fn     = FN_SUB;
        ctrl.acc_we = 1'b1;
      end
      OP_JUMP: begin
        ctrl.jump    = 1'b1;
        ctrl.force_z = 1'b1;
      end
      OP_JUMPZ: ctrl.jump = 1'b1;
      default:  ctrl.bad  = 1'b1;
    endcase
  end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  alu_fn_e           fn,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              force_z,
  output logic [DATA_W-1:0] y,
  output logic              z
);

  always_comb begin
    case (fn)
      FN_ADD:  y = a + b;
      FN_SUB:  y = a - b;
      default: y = b;
    endcase
  end

  assign z = force_z | (y == '0);

endmodule

// File: rtl/acc_next_pc.sv
module acc_next_pc #(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] pc_q,
  input  logic              jump,
  input  logic              zero,
  input  logic [ADDR_W-1:0] target,
  output logic [ADDR_W-1:0] pc_d
);

  logic taken;

  assign taken = jump & zero;
  assign pc_d  = taken ? target : pc_q + ADDR_W'(1);

endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] rom_addr,
  input  logic [DATA_W-1:0] rom_data,
  output logic [ADDR_W-1:0] ram_addr,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              ram_we,
  output logic              illegal
);

  localparam int CONST_W = DATA_W - OPC_W - 1;
  localparam int SRC_BIT = CONST_W;
  localparam int PAD_W   = DATA_W - CONST_W;

  logic [ADDR_W-1:0] pc_q, pc_d, addr_q;
  logic [DATA_W-1:0] acc_q;
  logic              rw_q, bad_q;

  logic [OPC_W-1:0]   opc;
  logic               src_mem;
  logic [CONST_W-1:0] cnst;
  logic [DATA_W-1:0]  opnd_b, alu_y;
  logic               alu_z, halt;
  ctrl_t              ctrl;

  // instruction fields
  assign opc     = rom_data[DATA_W-1 -: OPC_W];
  assign src_mem = rom_data[SRC_BIT];
  assign cnst    = rom_data[CONST_W-1:0];

  // operand select: zero-extended constant or RAM word
  assign opnd_b = src_mem ? ram_rdata : {{PAD_W{1'b0}}, cnst};

  acc_decode u_dec (
    .opc  (opc),
    .ctrl (ctrl)
  );

  acc_alu #(.DATA_W(DATA_W)) u_alu (
    .fn      (ctrl.fn),
    .a       (acc_q),
    .b       (opnd_b),
    .force_z (ctrl.force_z),
    .y       (alu_y),
    .z       (alu_z)
  );

  acc_next_pc #(.ADDR_W(ADDR_W)) u_pc (
    .pc_q   (pc_q),
    .jump   (ctrl.jump),
    .zero   (alu_z),
    .target (opnd_b[ADDR_W-1:0]),
    .pc_d   (pc_d)
  );

  assign halt = ctrl.bad | bad_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q   <= '0;
      addr_q <= '0;
      acc_q  <= '0;
      rw_q   <= 1'b1;
      bad_q  <= 1'b0;
    end else begin
      bad_q <= halt;
      if (halt) begin
        rw_q <= 1'b1;
      end else begin
        pc_q   <= pc_d;
        addr_q <= opnd_b[ADDR_W-1:0];
        rw_q   <= ~ctrl.store;
        if (ctrl.acc_we) acc_q <= alu_y;
      end
    end
  end

  assign rom_addr  = pc_q;
  assign ram_addr  = addr_q;
  assign ram_wdata = acc_q;
  assign ram_we    = ~rw_q;
  assign illegal   = bad_q;

endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] rom_addr,
  input logic [DATA_W-1:0] rom_data,
  input logic [ADDR_W-1:0] ram_addr,
  input logic [DATA_W-1:0] ram_wdata,
  input logic              ram_we,
  input logic              illegal
);

  logic [2:0] opc;
  logic       src_mem;
  logic       live;

  assign opc     = rom_data[DATA_W-1 -: 3];
  assign src_mem = rom_data[DATA_W-4];
  assign live    = !illegal && (opc != 3'd7);

  a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
    illegal |=> illegal);

  a_r9_pc_frozen: assert property (@(posedge clk) disable iff (rst)
    illegal |=> $stable(rom_addr));

  a_r6_store_writes: assert property (@(posedge clk) disable iff (rst)
    (live && opc == 3'd2) |=> ram_we);

  a_r6_no_stray_write: assert property (@(posedge clk) disable iff (rst)
    (live && opc != 3'd2) |=> !ram_we);

  a_r5_addr_from_const: assert property (@(posedge clk) disable iff (rst)
    (live && !src_mem) |=> ram_addr == $past(rom_data[ADDR_W-1:0]));

  a_r8_pc_step: assert property (@(posedge clk) disable iff (rst)
    (live && opc <= 3'd4) |=> rom_addr == ADDR_W'($past(rom_addr) + 1'b1));

  a_r4_acc_kept: assert property (@(posedge clk) disable iff (rst)
    (live && (opc == 3'd0 || opc == 3'd2 || opc == 3'd5 || opc == 3'd6))
      |=> $stable(ram_wdata));

  a_r7_jump_const: assert property (@(posedge clk) disable iff (rst)
    (live && opc == 3'd5 && !src_mem) |=> rom_addr == $past(rom_data[ADDR_W-1:0]));

endmodule

bind acc_core acc_core_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rom_addr  (rom_addr),
  .rom_data  (rom_data),
  .ram_addr  (ram_addr),
  .ram_wdata (ram_wdata),
  .ram_we    (ram_we),
  .illegal   (illegal)
);

// File: tb/acc_core_tb.sv
module acc_core_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] rom_addr, ram_addr;
  logic [15:0] rom_data, ram_rdata, ram_wdata;
  logic        ram_we, illegal;

  logic [15:0] rom [64];
  logic [15:0] ram [256];

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // reference state
  logic [11:0] m_pc, m_addr;
  logic [15:0] m_acc;
  logic        m_rw, m_ill;

  always #4 clk = ~clk;

  assign rom_data  = rom[rom_addr[5:0]];
  assign ram_rdata = ram[ram_addr[7:0]];

  always @(posedge clk) if (ram_we) ram[ram_addr[7:0]] <= ram_wdata;

  acc_core u_dut (
    .clk(clk), .rst(rst), .rom_addr(rom_addr), .rom_data(rom_data),
    .ram_addr(ram_addr), .ram_rdata(ram_rdata), .ram_wdata(ram_wdata),
    .ram_we(ram_we), .illegal(illegal)
  );

  function automatic logic [15:0] ins(int op, bit src, int k);
    return {op[2:0], src, k[11:0]};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_pc = '0; m_addr = '0; m_acc = '0; m_rw = 1'b1; m_ill = 1'b0;
  endtask

  // one instruction of the reference, per the requirements
  task automatic model_step();
    logic [15:0] w, b, y;
    logic [2:0]  op;
    w  = rom[m_pc[5:0]];
    op = w[15:13];
    b  = w[12] ? ram[m_addr[7:0]] : {4'b0, w[11:0]};
    if (m_ill || op == 3'd7) begin
      m_ill = 1'b1;
      m_rw  = 1'b1;
    end else begin
      case (op)
        3'd3:    y = m_acc + b;
        3'd4:    y = m_acc - b;
        default: y = b;
      endcase
      if (op == 3'd1 || op == 3'd3 || op == 3'd4) m_acc = y;
      if (op == 3'd5 || (op == 3'd6 && b == 16'd0)) m_pc = b[11:0];
      else m_pc = m_pc + 12'd1;
      m_addr = b[11:0];
      m_rw   = (op != 3'd2);
    end
  endtask

  task automatic compare();
    check("R7 rom_addr", {20'd0, rom_addr}, {20'd0, m_pc});
    check("R5 ram_addr", {20'd0, ram_addr}, {20'd0, m_addr});
    check("R6 ram_we", {31'd0, ram_we}, {31'd0, ~m_rw});
    check("R3 ram_wdata", {16'd0, ram_wdata}, {16'd0, m_acc});
    check("R9 illegal", {31'd0, illegal}, {31'd0, m_ill});
  endtask

  task automatic run(int n);
    repeat (n) begin
      compare();
      model_step();
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    model_reset();
    rst = 1'b0;
  endtask

  task automatic fill_rom_jump0();
    for (int i = 0; i < 64; i++) rom[i] = ins(5, 1'b0, 0);
  endtask

  initial begin
    void'($urandom(32'd20240607));
    for (int i = 0; i < 256; i++) ram[i] = 16'd0;
    fill_rom_jump0();

    // R1 reset state
    @(negedge clk);
    do_reset();
    check("R1 rom_addr", {20'd0, rom_addr}, 32'd0);
    check("R1 ram_addr", {20'd0, ram_addr}, 32'd0);
    check("R1 ram_wdata", {16'd0, ram_wdata}, 32'd0);
    check("R1 ram_we", {31'd0, ram_we}, 32'd0);
    check("R1 illegal", {31'd0, illegal}, 32'd0);

    // R10 increment loop
    rom[0] = ins(0, 1'b0, 2);
    rom[1] = ins(1, 1'b1, 0);
    rom[2] = ins(3, 1'b0, 1);
    rom[3] = ins(2, 1'b0, 2);
    rom[4] = ins(5, 1'b0, 0);
    ram[2] = 16'h00FE;
    do_reset();
    for (int p = 1; p <= 6; p++) begin
      run(5);
      check("R10 ram[2]", {16'd0, ram[2]}, 32'h00FE + p);
    end

    // R8 wrap from 0xFFF, R2 constant field
    fill_rom_jump0();
    rom[0]  = ins(5, 1'b0, 12'hFFF);
    rom[63] = ins(3, 1'b0, 5);
    do_reset();
    run(1);
    check("R7 jump to FFF", {20'd0, rom_addr}, 32'hFFF);
    run(1);
    check("R8 wrap to 0", {20'd0, rom_addr}, 32'd0);
    check("R2 const add", {16'd0, ram_wdata}, 32'd5);

    // R3 subtract wrap, R7 jumpz on operand
    fill_rom_jump0();
    rom[0] = ins(4, 1'b0, 1);
    rom[1] = ins(3, 1'b0, 2);
    rom[2] = ins(6, 1'b0, 5);
    rom[3] = ins(6, 1'b0, 0);
    do_reset();
    run(1);
    check("R3 sub wraps", {16'd0, ram_wdata}, 32'hFFFF);
    run(2);
    check("R7 jumpz not taken", {20'd0, rom_addr}, 32'd3);
    check("R4 jumpz keeps acc", {16'd0, ram_wdata}, 32'd1);
    run(1);
    check("R7 jumpz taken on zero operand", {20'd0, rom_addr}, 32'd0);

    // R6 store timing
    fill_rom_jump0();
    rom[0] = ins(3, 1'b0, 12'h123);
    rom[1] = ins(2, 1'b0, 12'h010);
    rom[2] = ins(0, 1'b0, 12'h020);
    ram[16] = 16'd0;
    do_reset();
    run(1);
    check("R6 no write before store", {31'd0, ram_we}, 32'd0);
    run(1);
    check("R6 write after store", {31'd0, ram_we}, 32'd1);
    check("R6 write addr", {20'd0, ram_addr}, 32'h010);
    check("R6 write data", {16'd0, ram_wdata}, 32'h123);
    run(1);
    check("R6 write ends", {31'd0, ram_we}, 32'd0);
    check("R6 ram committed", {16'd0, ram[16]}, 32'h123);

    // R9 illegal opcode
    fill_rom_jump0();
    rom[0] = ins(3, 1'b0, 7);
    rom[1] = ins(7, 1'b0, 3);
    do_reset();
    run(6);
    check("R9 flag set", {31'd0, illegal}, 32'd1);
    check("R9 pc held", {20'd0, rom_addr}, 32'd1);
    check("R9 acc held", {16'd0, ram_wdata}, 32'd7);
    check("R9 no write", {31'd0, ram_we}, 32'd0);
    do_reset();
    check("R1 reset clears illegal", {31'd0, illegal}, 32'd0);

    // random programs against the reference
    for (int t = 0; t < 10; t++) begin
      for (int i = 0; i < 64; i++)
        rom[i] = ins(int'($urandom_range(6, 0)), 1'($urandom_range(1, 0)),
                     int'($urandom_range(4095, 0)));
      for (int i = 0; i < 256; i++) ram[i] = 16'($urandom());
      if (t == 9) rom[int'($urandom_range(63, 0))] = ins(7, 1'b0, 0);
      do_reset();
      run(400);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule